// File: doc/BRIEF.md
# Variable Frame Length Extractor

This block sits on the receive path after sync detection. It watches a byte stream and reads a length field out of the first header bytes of every frame. It then counts the remaining bytes and flags the final byte of the frame, so frames whose size changes from one to the next are delimited in hardware with no software step.

The field is set up at run time in four ways:
- its width in bits;
- its starting bit within the header, so it may straddle two header bytes;
- the number of header bytes;
- whether the field's first wire bit is its most significant bit, while the rest of the frame keeps LSB-first order.

The length can either already count the trailing CRC bytes, or a configured CRC byte count is added to it. A length above a configured maximum is reported as an error, and the frame is dropped.

Header bits are numbered in wire order. Bit `i` of header byte `k` (byte 0 follows start-of-frame) is header bit `8*k+i`. Configuration is held stable while a frame is in progress.

Top module: `flx_frame_len`

## Requirements
- R1: After synchronous reset, `len_valid`, `len_err` and `last_byte` are 0, `frame_len` is 0, and the parser waits for a start-of-frame.
- R2: With `cfg_msb_first`=0, bit `j` of the length (for `j` < `cfg_len_bits`) equals header bit `cfg_len_pos+j`. Other header bits have no effect.
- R3: With `cfg_msb_first`=1, header bit `cfg_len_pos+j` becomes length bit `cfg_len_bits-1-j`, so the first wire bit of the field is its MSB.
- R4: The header is `cfg_hdr_bytes` bytes long (1 to MAX_HDR). A field may start at any bit position and cross a byte boundary, for example an 8-bit field at bit 2 of a 2-byte header, or a field lying wholly in the second byte.
- R5: One cycle after the clock edge that accepts the final header byte, `len_valid` pulses for one cycle and `frame_len` carries the extracted length L.
- R6: With `cfg_crc_incl`=1, `last_byte` is asserted on the frame byte with index `cfg_hdr_bytes+L-1`.
- R7: With `cfg_crc_incl`=0, `last_byte` is asserted on byte index `cfg_hdr_bytes+L+cfg_crc_bytes-1`.
- R8: If L exceeds `cfg_max_len`, then `len_err` pulses in place of `len_valid`, no `last_byte` follows, and the bytes that follow are ignored until the next start-of-frame. A length equal to the maximum is accepted.
- R9: A byte carrying `in_sof` with `in_valid` starts a new frame as its byte 0 in any state, which abandons a frame in progress.
- R10: `last_byte` is only asserted together with `in_valid`. Cycles without `in_valid` do not advance the byte count, and `in_sof` without `in_valid` has no effect.
- R11: When the counted body length is zero, `last_byte` is asserted on the final header byte itself.
- R12: Bytes with `in_valid` and no `in_sof` that arrive while no frame is open produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the byte as frame byte 0 |
| in_data | input | 8 | Received byte, bit 0 first on the wire |
| cfg_len_bits | input | $clog2(LEN_W+1) | Length field width in bits |
| cfg_len_pos | input | $clog2(8*MAX_HDR) | First header bit of the field |
| cfg_hdr_bytes | input | IDX_W+1 | Header length in bytes |
| cfg_msb_first | input | 1 | Field order: 1 means MSB first |
| cfg_crc_incl | input | 1 | 1 means the length already counts the CRC |
| cfg_crc_bytes | input | CRC_W | CRC bytes added when not included |
| cfg_max_len | input | LEN_W | Largest accepted length |
| frame_len | output | LEN_W | Extracted length |
| len_valid | output | 1 | One-cycle pulse: new length is available |
| last_byte | output | 1 | Current input byte ends the frame |
| len_err | output | 1 | One-cycle pulse: length over the maximum |

## Verification
The hardest cases to reach are those where the end of the frame falls on a header byte (zero body) or on the byte right after the header. In these cases the length report and the last-byte flag arrive in reversed order or in the same cycle. The stimulus builds headers around chosen lengths of 0 and 1 and encodes them into noisy header bits. The scoreboard queues the events in the order the requirements predict.

Other tests cover an over-limit frame followed by stray bytes, and a start-of-frame that cuts into an open body. A long frame with idle gaps, during which `in_sof` is raised without `in_valid`, checks that the byte count holds still.

// File: rtl/flx_pkg.sv
package flx_pkg;
    localparam int FLX_MAX_HDR_DEF = 4;
    localparam int FLX_LEN_W_DEF   = 12;
    localparam int FLX_CRC_W_DEF   = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_BODY = 2'd2
    } flx_phase_e;

    function automatic int flx_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/flx_hdr_capture.sv
module flx_hdr_capture #(
    parameter int MAX_HDR = 4,
    parameter int IDX_W   = 2,
    localparam int HB     = 8 * MAX_HDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             clear,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       data,
    output logic [HB-1:0]    hdr_now
);
    logic [HB-1:0] hdr_q;

    // Stored bytes merged with the byte arriving now, so the final
    // header byte can be decoded in the cycle it appears.
    always_comb begin
        hdr_now = clear ? '0 : hdr_q;
        if (wr_en) hdr_now[wr_idx*8 +: 8] = data;
    end

    always_ff @(posedge clk) begin
        if (rst)        hdr_q <= '0;
        else if (wr_en) hdr_q <= hdr_now;
    end

    // R9: a start-of-frame byte wipes every earlier header byte
    assert_sof_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && clear && wr_idx == '0) |=> (hdr_q[HB-1:8] == '0));
endmodule

// File: rtl/flx_len_decode.sv
module flx_len_decode #(
    parameter int MAX_HDR = 4,
    parameter int LEN_W   = 12,
    parameter int CRC_W   = 3,
    localparam int HB     = 8 * MAX_HDR,
    localparam int POS_W  = $clog2(HB),
    localparam int BITS_W = $clog2(LEN_W + 1)
) (
    input  logic [HB-1:0]     hdr,
    input  logic [POS_W-1:0]  cfg_pos,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic              cfg_msb,
    input  logic              cfg_crc_incl,
    input  logic [CRC_W-1:0]  cfg_crc_bytes,
    input  logic [LEN_W-1:0]  cfg_max,
    output logic [LEN_W-1:0]  len_val,
    output logic              over,
    output logic [LEN_W:0]    body
);
    always_comb begin
        len_val = '0;
        for (int j = 0; j < LEN_W; j++) begin
            if (j < int'(cfg_bits) && (int'(cfg_pos) + j) < HB) begin
                if (cfg_msb) len_val[int'(cfg_bits) - 1 - j] = hdr[int'(cfg_pos) + j];
                else         len_val[j]                       = hdr[int'(cfg_pos) + j];
            end
        end
    end

    always_comb begin
        over = (len_val > cfg_max);
        body = {1'b0, len_val} + (cfg_crc_incl ? '0 : (LEN_W+1)'(cfg_crc_bytes));
    end
endmodule

// File: rtl/flx_body_counter.sv
module flx_body_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem
);
    always_ff @(posedge clk) begin
        if (rst)       rem <= '0;
        else if (load) rem <= load_val;
        else if (dec)  rem <= rem - CNT_W'(1);
    end

    // R10: each accepted body byte removes exactly one from the count
    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (rem == $past(rem) - CNT_W'(1)));

    // R6: the count never wraps below zero
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        dec |-> (rem != '0));
endmodule

// File: rtl/flx_frame_len.sv
module flx_frame_len #(
    parameter int MAX_HDR  = flx_pkg::FLX_MAX_HDR_DEF,
    parameter int LEN_W    = flx_pkg::FLX_LEN_W_DEF,
    parameter int CRC_W    = flx_pkg::FLX_CRC_W_DEF,
    localparam int IDX_W   = flx_pkg::flx_idx_w(MAX_HDR),
    localparam int POS_W   = $clog2(8 * MAX_HDR),
    localparam int BITS_W  = $clog2(LEN_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_data,
    input  logic [BITS_W-1:0] cfg_len_bits,
    input  logic [POS_W-1:0]  cfg_len_pos,
    input  logic [IDX_W:0]    cfg_hdr_bytes,
    input  logic              cfg_msb_first,
    input  logic              cfg_crc_incl,
    input  logic [CRC_W-1:0]  cfg_crc_bytes,
    input  logic [LEN_W-1:0]  cfg_max_len,
    output logic [LEN_W-1:0]  frame_len,
    output logic              len_valid,
    output logic              last_byte,
    output logic              len_err
);
    import flx_pkg::*;

    localparam int HB    = 8 * MAX_HDR;
    localparam int CNT_W = LEN_W + 1;

    flx_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
    logic             start, hdr_byte, hdr_final, body_byte, good;
    logic [HB-1:0]    hdr_now;
    logic [LEN_W-1:0] len_val;
    logic             over;
    logic [CNT_W-1:0] body, rem;

    always_comb begin
        start     = in_valid && in_sof;
        cur_idx   = start ? '0 : idx_q;
        hdr_byte  = in_valid && (start || phase_q == PH_HDR);
        hdr_final = hdr_byte && ({1'b0, cur_idx} == cfg_hdr_bytes - 1'b1);
        body_byte = in_valid && !start && phase_q == PH_BODY;
        good      = hdr_final && !over;
    end

    flx_hdr_capture #(.MAX_HDR(MAX_HDR), .IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst(rst), .wr_en(hdr_byte), .clear(start),
        .wr_idx(cur_idx), .data(in_data), .hdr_now(hdr_now)
    );

    flx_len_decode #(.MAX_HDR(MAX_HDR), .LEN_W(LEN_W), .CRC_W(CRC_W)) u_dec (
        .hdr(hdr_now), .cfg_pos(cfg_len_pos), .cfg_bits(cfg_len_bits),
        .cfg_msb(cfg_msb_first), .cfg_crc_incl(cfg_crc_incl),
        .cfg_crc_bytes(cfg_crc_bytes), .cfg_max(cfg_max_len),
        .len_val(len_val), .over(over), .body(body)
    );

    flx_body_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(good), .load_val(body),
        .dec(body_byte), .rem(rem)
    );

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (hdr_final) begin
            phase_d = (over || body == '0) ? PH_IDLE : PH_BODY;
        end else if (hdr_byte) begin
            phase_d = PH_HDR;
            idx_d   = cur_idx + 1'b1;
        end else if (body_byte && rem == CNT_W'(1)) begin
            phase_d = PH_IDLE;
        end
    end

    assign last_byte = (good && body == '0) || (body_byte && rem == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            idx_q     <= '0;
            frame_len <= '0;
            len_valid <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            idx_q     <= idx_d;
            len_valid <= good;
            len_err   <= hdr_final && over;
            if (good) frame_len <= len_val;
        end
    end

    // R8: an oversize frame is closed and reported as error only
    assert_err_drop_R8: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (phase_q == PH_IDLE && !len_valid));

    // R8: every accepted length respects the limit
    assert_len_limit_R8: assert property (@(posedge clk) disable iff (rst)
        len_valid |-> (frame_len <= cfg_max_len));

    // R10: the end flag only rides on a strobed byte
    assert_last_valid_R10: assert property (@(posedge clk) disable iff (rst)
        last_byte |-> in_valid);

    // R6: an open body always has bytes outstanding
    assert_body_open_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY) |-> (rem != '0));

    // R9: start-of-frame into a multi-byte header opens header capture
    assert_sof_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (start && cfg_hdr_bytes > 1) |=> (phase_q == PH_HDR));
endmodule

// File: tb/sim_flx_frame_len.sv
module sim_flx_frame_len;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int K_LEN = 0, K_LAST = 1, K_ERR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [3:0]  cfg_len_bits = 4'd7;
    logic [4:0]  cfg_len_pos = '0;
    logic [2:0]  cfg_hdr_bytes = 3'd1;
    logic        cfg_msb_first = 1'b0, cfg_crc_incl = 1'b1;
    logic [2:0]  cfg_crc_bytes = 3'd2;
    logic [11:0] cfg_max_len = 12'd127;
    logic [11:0] frame_len;
    logic        len_valid, last_byte, len_err;

    int n_cmp = 0, n_bad = 0;
    int cur_pos = -1;
    int q_kind[$], q_val[$];
    string q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flx_frame_len u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .cfg_len_bits(cfg_len_bits), .cfg_len_pos(cfg_len_pos), .cfg_hdr_bytes(cfg_hdr_bytes),
        .cfg_msb_first(cfg_msb_first), .cfg_crc_incl(cfg_crc_incl), .cfg_crc_bytes(cfg_crc_bytes),
        .cfg_max_len(cfg_max_len), .frame_len(frame_len), .len_valid(len_valid),
        .last_byte(last_byte), .len_err(len_err)
    );

    function automatic string kname(input int k);
        return (k == K_LEN) ? "LEN" : (k == K_LAST) ? "LAST" : "ERR";
    endfunction

    task automatic expect_ev(input int k, input int v, input string req);
        q_kind.push_back(k); q_val.push_back(v); q_req.push_back(req);
    endtask

    task automatic observe(input int k, input int v);
        n_cmp++;
        if (q_kind.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: actual %s %0d, expected none (R8/R12)", kname(k), v);
        end else begin
            int ek = q_kind.pop_front();
            int ev = q_val.pop_front();
            string er = q_req.pop_front();
            if (ek != k || ev != v) begin
                n_bad++;
                $display("FAIL %s: actual %s %0d, expected %s %0d", er, kname(k), v, kname(ek), ev);
            end
        end
    endtask

    // Monitor: sample away from the active edge; length/error before end flag
    always @(negedge clk) begin
        if (!rst) begin
            if (len_err)   observe(K_ERR, 0);
            if (len_valid) observe(K_LEN, int'(frame_len));
            if (last_byte) observe(K_LAST, cur_pos);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sof = 1'b0; cur_pos = -1;
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input logic sof, input int pos);
        @(posedge clk); #1;
        in_valid = 1'b1; in_sof = sof; in_data = d; cur_pos = pos;
    endtask

    task automatic junk(input int n);
        for (int i = 0; i < n; i++) put_byte(8'(8'h3C + i * 29), 1'b0, -1);
        idle(1);
    endtask

    // Driver: encode L into a noisy header, queue the predicted events, send nsend bytes
    task automatic run_frame(input int hdr, input int pos, input int w, input bit msb,
                             input bit incl, input int crcb, input int maxl, input int L,
                             input int nsend, input bit gaps, input string req);
        logic [31:0] hv;
        int lm, body;
        cfg_hdr_bytes = 3'(hdr); cfg_len_pos = 5'(pos); cfg_len_bits = 4'(w);
        cfg_msb_first = msb; cfg_crc_incl = incl; cfg_crc_bytes = 3'(crcb);
        cfg_max_len = 12'(maxl);
        hv = 32'hA5C3_96E1 ^ (32'(L) * 32'h0101_0101);
        for (int j = 0; j < w; j++) hv[pos + j] = msb ? L[w - 1 - j] : L[j];
        lm = L & ((1 << w) - 1);
        body = lm + (incl ? 0 : crcb);
        if (nsend >= hdr) begin
            if (lm > maxl) expect_ev(K_ERR, 0, req);
            else if (body == 0) begin
                expect_ev(K_LAST, hdr - 1, req);
                expect_ev(K_LEN, lm, req);
            end else begin
                expect_ev(K_LEN, lm, req);
                if (nsend >= hdr + body) expect_ev(K_LAST, hdr + body - 1, req);
            end
        end
        for (int k = 0; k < nsend; k++) begin
            if (gaps && k > 0) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_sof = 1'b1; cur_pos = -1;
            end
            put_byte((k < hdr) ? hv[8*k +: 8] : 8'(k * 13 + 1), k == 0, k);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (len_valid || len_err || last_byte || frame_len != '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual v=%0b e=%0b l=%0b len=%0d, expected all 0",
                     len_valid, len_err, last_byte, frame_len);
        end
        junk(4);                                                       // R12
        run_frame(1, 0, 7, 0, 1, 2, 127, 5, 6, 0, "R2/R6");   idle(2);
        run_frame(2, 0, 11, 1, 0, 2, 2047, 9, 13, 0, "R3/R7"); idle(2);
        run_frame(2, 2, 8, 0, 1, 2, 255, 20, 22, 1, "R4/R10"); idle(2);
        run_frame(2, 8, 8, 0, 1, 2, 255, 3, 5, 0, "R4 second byte"); idle(2);
        run_frame(1, 0, 7, 0, 1, 2, 10, 40, 1, 0, "R8 over max"); idle(1);
        junk(5);                                                       // R8 dropped bytes
        run_frame(1, 0, 7, 0, 1, 2, 30, 30, 31, 0, "R8 equal max"); idle(2);
        run_frame(1, 0, 7, 0, 1, 2, 127, 0, 1, 0, "R11 zero body"); idle(2);
        run_frame(2, 0, 8, 0, 1, 2, 255, 1, 3, 0, "R5 one-byte body"); idle(2);
        run_frame(1, 0, 7, 0, 1, 2, 127, 20, 6, 0, "R9 abandoned");
        run_frame(1, 0, 7, 0, 1, 2, 127, 4, 5, 0, "R9 restart"); idle(2);
        run_frame(4, 20, 12, 1, 0, 4, 4095, 7, 15, 0, "R3/R7 wide"); idle(4);
        n_cmp++;
        if (q_kind.size() != 0) begin
            n_bad++;
            $display("FAIL R5/R6 missing events: actual %0d pending, expected 0", q_kind.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule